// File: doc/BRIEF.md
# Periodic Cache Purge Controller

This block shortens how long data sits unprotected in a first-level cache by emptying that cache on a fixed cycle period. A free-running interval counter fires once every programmed number of cycles. When it fires, the controller purges the cache attached to it. Typical periods are on the order of ten thousand to a million cycles. The purge is driven by elapsed time, for reliability, and not by any coherence event.

A mode input selects what kind of cache is attached. In instruction mode, the purge is a single-cycle strobe that clears every valid bit at once. In data mode, the controller walks every line, ordered by set and then by way. Each line that is valid and modified is handed to the second-level write-back port before it is invalidated. Clean valid lines are invalidated with no traffic on that port. Lines that are not valid are skipped.

While a data walk runs, a busy output tells the CPU side to hold off cache accesses. A done pulse marks the end of each purge, and the interval count starts again from zero once the walk finishes.

Top module: `cache_purge_ctrl`

## Requirements
- R1: After a synchronous reset, busy, done, inval_all, wb_req and line_inval are all low.
- R2: With cfg_enable high and cfg_interval equal to N (N > 0) in instruction mode, inval_all pulses exactly once every N cycles.
- R3: When cfg_enable is low or cfg_interval is zero, no purge starts: inval_all and busy stay low.
- R4: In instruction mode (cfg_is_dcache = 0), a purge is a single-cycle inval_all strobe with done high in the same cycle, busy stays low, and no write-back is requested.
- R5: In data mode (cfg_is_dcache = 1), the walk visits line index set*WAYS+way in ascending order, starting at set 0 way 0, so write-backs are accepted in ascending line index.
- R6: During a walk, every line that is valid and dirty gets exactly one write-back. A valid clean line is invalidated with no write-back. A line that is not valid is left alone even if its dirty input is high. After the walk, no line is valid.
- R7: A dirty line is invalidated only in the cycle its write-back is accepted (wb_req and wb_ready both high).
- R8: While wb_req is high and wb_ready is low, the walk holds its set and way and keeps wb_req high.
- R9: busy is high for exactly SETS*WAYS cycles plus one cycle for each stalled write-back cycle. done pulses for one cycle as busy falls.
- R10: In data mode, the next walk begins (busy rises) exactly N cycles after the done pulse of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Enables periodic purging |
| cfg_interval | input | CNT_W | Purge period in cycles; zero disables |
| cfg_is_dcache | input | 1 | 1 = data cache walk, 0 = instruction cache clear-all |
| scan_set | output | SET_W | Set index of the line under examination |
| scan_way | output | WAY_W | Way index of the line under examination |
| line_valid | input | 1 | Valid bit of the addressed line (same cycle) |
| line_dirty | input | 1 | Dirty bit of the addressed line (same cycle) |
| wb_req | output | 1 | Write-back request for the addressed line to the second level |
| wb_ready | input | 1 | Second level accepts the write-back this cycle |
| line_inval | output | 1 | Clear valid and dirty of the addressed line |
| inval_all | output | 1 | Single-cycle clear of every valid bit (instruction mode) |
| busy | output | 1 | Data walk in progress; CPU cache access must stall |
| done | output | 1 | One-cycle pulse at the end of each purge |

## Verification
The bench builds the block with 4 sets, 2 ways and a 16-bit interval, so that a full walk is only eight lines long. With this size, every line position, including the first and last line of the walk, can be marked valid, dirty or both through an 8-bit mask. Short intervals of 2 to 8 cycles let several periods, restarts and both modes fit in a short run. A programmable per-request ready delay is used to produce stalled write-backs of different lengths, so the walk length can be predicted from the dirty count.

// File: rtl/purge_pkg.sv
package purge_pkg;
  typedef enum logic {
    PG_IDLE = 1'b0,
    PG_WALK = 1'b1
  } pg_state_e;
endpackage

// File: rtl/purge_timer.sv
module purge_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] interval,
  input  logic             hold,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed;

  assign armed = enable && (interval != '0) && !hold;
  assign fire  = armed && (cnt_q == interval - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !armed) begin
      cnt_q <= '0;
    end else if (fire) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R10
  hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt_q == '0));
endmodule

// File: rtl/purge_walker.sv
module purge_walker #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int SET_W = 6,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output logic [SET_W-1:0] set_idx,
  output logic [WAY_W-1:0] way_idx,
  output logic             last
);
  localparam logic [SET_W-1:0] SET_MAX = SET_W'(SETS - 1);
  localparam logic [WAY_W-1:0] WAY_MAX = WAY_W'(WAYS - 1);

  logic [SET_W-1:0] set_q;
  logic [WAY_W-1:0] way_q;

  assign set_idx = set_q;
  assign way_idx = way_q;
  assign last    = (set_q == SET_MAX) && (way_q == WAY_MAX);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      set_q <= '0;
      way_q <= '0;
    end else if (step) begin
      if (last) begin
        set_q <= '0;
        way_q <= '0;
      end else if (way_q == WAY_MAX) begin
        way_q <= '0;
        set_q <= set_q + 1'b1;
      end else begin
        way_q <= way_q + 1'b1;
      end
    end
  end

  // R5
  walk_order_chk: assert property (@(posedge clk) disable iff (rst || clear)
    step && !last |=> ((set_q == $past(set_q)) && (way_q == $past(way_q) + 1'b1)) ||
                      ((way_q == '0) && (set_q == $past(set_q) + 1'b1)));
endmodule

// File: rtl/cache_purge_ctrl.sv
module cache_purge_ctrl
  import purge_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int CNT_W = 20,
  parameter int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_enable,
  input  logic [CNT_W-1:0] cfg_interval,
  input  logic             cfg_is_dcache,
  output logic [SET_W-1:0] scan_set,
  output logic [WAY_W-1:0] scan_way,
  input  logic             line_valid,
  input  logic             line_dirty,
  output logic             wb_req,
  input  logic             wb_ready,
  output logic             line_inval,
  output logic             inval_all,
  output logic             busy,
  output logic             done
);
  pg_state_e state_q;
  logic      done_q;
  logic      inval_all_q;
  logic      walking;
  logic      fire;
  logic      step;
  logic      last_line;
  logic      needs_wb;

  assign walking  = (state_q == PG_WALK);
  assign needs_wb = line_valid && line_dirty;

  purge_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .enable   (cfg_enable),
    .interval (cfg_interval),
    .hold     (walking),
    .fire     (fire)
  );

  purge_walker #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) walker_i (
    .clk     (clk),
    .rst     (rst),
    .clear   (!walking),
    .step    (step),
    .set_idx (scan_set),
    .way_idx (scan_way),
    .last    (last_line)
  );

  assign step       = walking && (!needs_wb || wb_ready);
  assign wb_req     = walking && needs_wb;
  assign line_inval = walking && line_valid && (!line_dirty || wb_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= PG_IDLE;
      done_q      <= 1'b0;
      inval_all_q <= 1'b0;
    end else begin
      done_q      <= 1'b0;
      inval_all_q <= 1'b0;
      case (state_q)
        PG_IDLE: begin
          if (fire) begin
            if (cfg_is_dcache) begin
              state_q <= PG_WALK;
            end else begin
              inval_all_q <= 1'b1;
              done_q      <= 1'b1;
            end
          end
        end
        PG_WALK: begin
          if (step && last_line) begin
            state_q <= PG_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= PG_IDLE;
      endcase
    end
  end

  assign busy      = walking;
  assign done      = done_q;
  assign inval_all = inval_all_q;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wb_req && !wb_ready |=> wb_req && $stable(scan_set) && $stable(scan_way));

  // R7
  wb_before_inval_chk: assert property (@(posedge clk) disable iff (rst)
    line_inval && line_dirty |-> wb_req && wb_ready);

  // R9
  done_ends_walk_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R4
  iflush_chk: assert property (@(posedge clk) disable iff (rst)
    inval_all |-> done && !busy && !wb_req);

  // R3
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy && (!cfg_enable || cfg_interval == '0) |=> !inval_all && !busy);
endmodule

// File: tb/cache_purge_ctrl_tb_top.sv
`timescale 1ns/1ps
module cache_purge_ctrl_tb_top;
  localparam int SETS  = 4;
  localparam int WAYS  = 2;
  localparam int CNT_W = 16;
  localparam int LINES = SETS * WAYS;
  localparam int NVEC  = 6;
  // interval[27:20] valid[19:12] dirty[11:4] ready_gap[3:0]
  localparam logic [27:0] VEC [NVEC] = '{
    {8'd4, 8'hFF, 8'h00, 4'd0},
    {8'd6, 8'hFF, 8'hFF, 4'd0},
    {8'd3, 8'hA5, 8'h3C, 4'd2},
    {8'd8, 8'h00, 8'hFF, 4'd1},
    {8'd2, 8'h81, 8'h81, 4'd3},
    {8'd5, 8'h7E, 8'h5A, 4'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_enable = 1'b0;
  logic [CNT_W-1:0] cfg_interval = '0;
  logic cfg_is_dcache = 1'b0;
  logic [1:0] scan_set;
  logic [0:0] scan_way;
  logic line_valid, line_dirty, wb_req, wb_ready, line_inval, inval_all, busy, done;

  always #2.5 clk = ~clk;

  cache_purge_ctrl #(.SETS(SETS), .WAYS(WAYS), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_interval(cfg_interval),
    .cfg_is_dcache(cfg_is_dcache), .scan_set(scan_set), .scan_way(scan_way),
    .line_valid(line_valid), .line_dirty(line_dirty), .wb_req(wb_req),
    .wb_ready(wb_ready), .line_inval(line_inval), .inval_all(inval_all),
    .busy(busy), .done(done)
  );

  // cache model and monitors
  logic [LINES-1:0] mv = '0, md = '0, ld_v = '0, ld_d = '0;
  logic ld_go = 1'b0;
  int gap_cur = 0, rcnt = 0, cyc = 0;
  int wlog [64];
  int wn = 0, bad_inval = 0, busy_cnt = 0, done_cnt = 0;
  logic p_all = 0, p_inv = 0, p_acc = 0, p_req = 0, p_bad = 0;
  int p_idx = 0;
  int tests = 0, fails = 0;
  int lidx;

  assign lidx       = int'(scan_set) * WAYS + int'(scan_way);
  assign line_valid = mv[lidx];
  assign line_dirty = md[lidx];
  assign wb_ready   = (rcnt >= gap_cur);

  always @(negedge clk) begin
    p_all <= inval_all;
    p_inv <= line_inval;
    p_acc <= wb_req && wb_ready;
    p_req <= wb_req;
    p_idx <= lidx;
    p_bad <= line_inval && line_dirty && !(wb_req && wb_ready);
    if (busy) busy_cnt <= busy_cnt + 1;
    if (done) done_cnt <= done_cnt + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ld_go) begin
      mv <= ld_v;
      md <= ld_d;
    end else begin
      if (p_all) mv <= '0;
      if (p_inv) begin
        mv[p_idx] <= 1'b0;
        md[p_idx] <= 1'b0;
      end
    end
    if (p_acc) begin
      wlog[wn % 64] <= p_idx;
      wn <= wn + 1;
      rcnt <= 0;
    end else if (p_req) begin
      rcnt <= rcnt + 1;
    end else begin
      rcnt <= 0;
    end
    if (p_bad) bad_inval <= bad_inval + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [LINES-1:0] v, input logic [LINES-1:0] d);
    @(negedge clk);
    ld_v = v; ld_d = d; ld_go = 1'b1;
    @(negedge clk);
    ld_go = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    if (!seen) chk("R9 done timeout", 0, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit seen;
    int pulses[3];
    int np, busy_seen, t_done;

    // R1 reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 inval_all", inval_all, 0);
    chk("R1 wb_req", wb_req, 0);
    chk("R1 line_inval", line_inval, 0);

    // R3 interval zero, then enable low
    load(8'hFF, 8'hFF);
    cfg_is_dcache = 1'b0; cfg_interval = '0; cfg_enable = 1'b1;
    np = 0; busy_seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (inval_all) np++;
      if (busy) busy_seen++;
    end
    chk("R3 zero interval pulses", np, 0);
    cfg_enable = 1'b0; cfg_interval = 3; cfg_is_dcache = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (inval_all) np++;
      if (busy) busy_seen++;
    end
    chk("R3 disabled pulses", np, 0);
    chk("R3 disabled busy", busy_seen, 0);
    chk("R3 model untouched", int'(mv), 8'hFF);

    // R2 / R4 instruction mode period
    load(8'hFF, 8'h0F);
    begin
      int wn0 = wn;
      cfg_is_dcache = 1'b0; cfg_interval = 5; cfg_enable = 1'b1;
      np = 0; busy_seen = 0;
      for (int i = 0; i < 200 && np < 3; i++) begin
        @(negedge clk);
        if (busy) busy_seen++;
        if (inval_all) begin
          pulses[np] = cyc;
          np++;
          chk("R4 done with strobe", done, 1);
        end
      end
      cfg_enable = 1'b0;
      @(negedge clk);
      chk("R2 pulse count", np, 3);
      chk("R2 gap 1", pulses[1] - pulses[0], 5);
      chk("R2 gap 2", pulses[2] - pulses[1], 5);
      chk("R4 busy stays low", busy_seen, 0);
      chk("R4 no write-back", wn - wn0, 0);
      chk("R4 valids cleared", int'(mv), 0);
    end

    // data mode vector table
    for (int k = 0; k < NVEC; k++) begin
      logic [LINES-1:0] v, d, vd;
      int nd, b0, d0, w0, x0, j;
      v = VEC[k][19:12]; d = VEC[k][11:4];
      vd = v & d;
      nd = $countones(vd);
      load(v, d);
      gap_cur = int'(VEC[k][3:0]);
      b0 = busy_cnt; d0 = done_cnt; w0 = wn; x0 = bad_inval;
      cfg_is_dcache = 1'b1; cfg_interval = CNT_W'(VEC[k][27:20]); cfg_enable = 1'b1;
      wait_done(seen);
      cfg_enable = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R6 write-back count", wn - w0, nd);
      j = 0;
      for (int l = 0; l < LINES; l++) begin
        if (vd[l]) begin
          chk("R5 write-back order", wlog[(w0 + j) % 64], l);
          j++;
        end
      end
      chk("R6 all invalid after walk", int'(mv), 0);
      chk("R9 busy length", busy_cnt - b0, LINES + gap_cur * nd);
      chk("R9 single done", done_cnt - d0, 1);
      chk("R7 no early invalidate", bad_inval - x0, 0);
      chk("R8 busy low after walk", busy, 0);
    end

    // R10 restart after a data walk
    load(8'hFF, 8'h00);
    gap_cur = 0;
    cfg_is_dcache = 1'b1; cfg_interval = 7; cfg_enable = 1'b1;
    wait_done(seen);
    t_done = cyc;
    seen = 0;
    for (int i = 0; i < 100 && !seen; i++) begin
      @(negedge clk);
      if (busy) seen = 1;
    end
    chk("R10 restart distance", cyc - t_done, 7);
    wait_done(seen);
    cfg_enable = 1'b0;
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule